// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing controller of a successive-approximation converter. It times a conversion in half ADC clock cycles. A single-cycle enable `half_tick` comes from an outside prescaler and runs at twice the ADC clock rate. From the start of a conversion the block raises a sample-and-hold strobe at a fixed point. At the end it marks completion: it loads a stub result, raises a one-cycle valid pulse, sets a sticky interrupt flag and latches the input-selection code for the next conversion.

A conversion can start in three ways. Software can start a single conversion. Free-running operation restarts the converter by itself at each completion. A rising edge on an external trigger can also start one, and this also sends a one-cycle realignment pulse to the prescaler. The first conversion after enable is a long warm-up conversion. In differential mode the block follows an internal clock at half the ADC rate. When a start lands in that clock's high phase, the sample point and the end point move two half cycles later.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy`, `sh_strobe`, `res_valid`, `mux_upd`, `presc_clr` and `irq_flag` are 0, and `result` and `mux_q` are 0.
- R2: The first conversion after `adc_en` rises gives `sh_strobe` 29 half ticks after the start tick and completes 50 half ticks after it (14.5 and 25 ADC cycles).
- R3: Any other software-started single-ended conversion strobes at 3 half ticks and completes at 26 half ticks. A request accepted on one clock starts on the next `half_tick` after it.
- R4: With `auto_en` set, a rising edge of `trig_in` starts a conversion that strobes at 4 half ticks and completes at 27. On the clock after the edge, `presc_clr` pulses for one cycle, and the half-rate phase restarts at 0.
- R5: The half-rate clock is bit 1 of a 2-bit count of half ticks. The count clears on disable and on an accepted trigger. With `diff_mode` set, a non-trigger, non-first start taken while that bit is 1 strobes at 5 and completes at 28. A start taken while it is 0 follows R3.
- R6: At completion `res_valid` and `mux_upd` pulse for one clock, `irq_flag` is set, `result` holds `sample_in` zero-extended to 16 bits, and `mux_q` takes `mux_in`. `mux_q` also takes `mux_in` when a conversion starts from idle.
- R7: With `free_run` set and `auto_en` clear, the next conversion starts on the completion tick itself, so completions are 26 half ticks apart.
- R8: A start request while `busy` is 1 is ignored.
- R9: `irq_flag` stays set until `flag_clr` is 1. Completion in the same clock as `flag_clr` leaves it set.
- R10: Clearing `adc_en` drops `busy` on the next clock and re-arms the long first conversion.
- R11: `sw_start` has no effect while `auto_en` is 1. `trig_in` has no effect while `auto_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_en | input | 1 | Converter enable |
| half_tick | input | 1 | Prescaler enable at twice the ADC clock rate |
| sw_start | input | 1 | Software start request |
| auto_en | input | 1 | Select external-trigger starts |
| free_run | input | 1 | Restart at every completion |
| trig_in | input | 1 | External trigger level (rising edge used) |
| diff_mode | input | 1 | Differential channel timing |
| flag_clr | input | 1 | Write-one clear of the interrupt flag |
| mux_in | input | MUX_W | Channel and reference selection to latch |
| sample_in | input | RES_W | Stub conversion data |
| busy | output | 1 | Request pending or conversion running |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| presc_clr | output | 1 | Prescaler realignment pulse |
| mux_upd | output | 1 | Selection latched at completion |
| mux_q | output | MUX_W | Latched selection |
| irq_flag | output | 1 | Sticky completion flag |
| res_valid | output | 1 | One-clock completion pulse |
| result | output | 16 | Right-justified result |

## Verification
The bench builds the block with its defaults: RES_W of 10 and MUX_W of 5, the timing windows of 50/29, 26/3, 27/4 and 28/5 half ticks, and the differential variant present. The 10-bit result inside the 16-bit output makes the zero-extension visible. With the differential variant built in, the half-rate phase selection can be reached. `half_tick` arrives every third clock, so trigger edges and requests land both on and off tick cycles. Repeated differential starts reach both half-rate phases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int unsigned TW = 8;

   typedef enum logic [1:0] {
      KIND_NORM,
      KIND_FIRST,
      KIND_TRIG,
      KIND_DIFF
   } kind_e;

   typedef struct packed {
      logic [TW-1:0] len;
      logic [TW-1:0] shp;
   } win_t;
endpackage

// File: rtl/adc_phase_gen.sv
module adc_phase_gen #(
   parameter int PH_W = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic realign,
   output logic hr
);
   if (PH_W < 2) begin : g_bad_w
      $error("PH_W must be at least 2");
   end

   logic [PH_W-1:0] ph;

   always_ff @(posedge clk) begin
      if (!rst_n)              ph <= '0;
      else if (!en || realign) ph <= '0;
      else if (tick)           ph <= ph + 1'b1;
   end

   assign hr = ph[1];
endmodule

// File: rtl/adc_start_ctl.sv
module adc_start_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic sw_start,
   input  logic auto_en,
   input  logic trig_in,
   input  logic running,
   input  logic take,
   output logic pend,
   output logic pend_trig,
   output logic trig_acc,
   output logic presc_clr
);
   logic trig_d;
   logic idle_ok;
   logic sw_acc;

   assign idle_ok  = en & ~pend & ~running;
   assign trig_acc = idle_ok & auto_en & trig_in & ~trig_d;
   assign sw_acc   = idle_ok & ~auto_en & sw_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trig_d    <= 1'b0;
         presc_clr <= 1'b0;
         pend      <= 1'b0;
         pend_trig <= 1'b0;
      end else begin
         trig_d    <= trig_in;
         presc_clr <= trig_acc;
         if (!en) begin
            pend      <= 1'b0;
            pend_trig <= 1'b0;
         end else if (take) begin
            pend <= 1'b0;
         end else if (trig_acc || sw_acc) begin
            pend      <= 1'b1;
            pend_trig <= trig_acc;
         end
      end
   end
endmodule

// File: rtl/adc_timebase.sv
module adc_timebase
   import adc_seq_pkg::*;
#(
   parameter int LEN_FIRST = 50,
   parameter int SH_FIRST  = 29,
   parameter int LEN_NORM  = 26,
   parameter int SH_NORM   = 3,
   parameter int LEN_TRIG  = 27,
   parameter int SH_TRIG   = 4,
   parameter int LEN_DIFF  = 28,
   parameter int SH_DIFF   = 5,
   parameter bit DIFF_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic tick,
   input  logic take,
   input  logic pend_trig,
   input  logic free_run,
   input  logic auto_en,
   input  logic diff_mode,
   input  logic hr,
   output logic running,
   output logic sh_ev,
   output logic done_ev
);
   if (SH_FIRST >= LEN_FIRST || SH_NORM >= LEN_NORM ||
       SH_TRIG >= LEN_TRIG || SH_DIFF >= LEN_DIFF) begin : g_bad_sh
      $error("sample point must precede completion");
   end
   if (LEN_FIRST >= (1 << TW) || LEN_DIFF >= (1 << TW)) begin : g_bad_len
      $error("window exceeds counter width");
   end

   function automatic win_t pick(kind_e k);
      win_t w;
      case (k)
         KIND_FIRST: begin w.len = TW'(LEN_FIRST); w.shp = TW'(SH_FIRST); end
         KIND_TRIG:  begin w.len = TW'(LEN_TRIG);  w.shp = TW'(SH_TRIG);  end
         KIND_DIFF:  begin w.len = TW'(LEN_DIFF);  w.shp = TW'(SH_DIFF);  end
         default:    begin w.len = TW'(LEN_NORM);  w.shp = TW'(SH_NORM);  end
      endcase
      return w;
   endfunction

   logic          diff_hi;
   logic          first_q;
   logic [TW-1:0] cnt;
   logic [TW-1:0] nxt;
   win_t          win;
   kind_e         start_kind;
   kind_e         rerun_kind;

   if (DIFF_EN) begin : g_diff
      assign diff_hi = diff_mode & hr;
   end else begin : g_nodiff
      logic unused_diff;
      assign unused_diff = diff_mode ^ hr;
      assign diff_hi     = 1'b0;
   end

   always_comb begin
      if (first_q)        start_kind = KIND_FIRST;
      else if (pend_trig) start_kind = KIND_TRIG;
      else if (diff_hi)   start_kind = KIND_DIFF;
      else                start_kind = KIND_NORM;
      rerun_kind = diff_hi ? KIND_DIFF : KIND_NORM;
   end

   assign nxt     = cnt + 1'b1;
   assign done_ev = en & running & tick & ~take & (nxt == win.len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         first_q <= 1'b1;
         cnt     <= '0;
         win     <= '0;
         sh_ev   <= 1'b0;
      end else begin
         sh_ev <= 1'b0;
         if (!en) begin
            running <= 1'b0;
            first_q <= 1'b1;
            cnt     <= '0;
         end else if (take) begin
            running <= 1'b1;
            cnt     <= '0;
            win     <= pick(start_kind);
            first_q <= 1'b0;
         end else if (running && tick) begin
            if (nxt == win.shp) sh_ev <= 1'b1;
            if (nxt == win.len) begin
               if (free_run && !auto_en) begin
                  cnt <= '0;
                  win <= pick(rerun_kind);
               end else begin
                  running <= 1'b0;
               end
            end else begin
               cnt <= nxt;
            end
         end
      end
   end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
   parameter int RES_W     = 10,
   parameter int OUT_W     = 16,
   parameter int MUX_W     = 5,
   parameter int LEN_FIRST = 50,
   parameter int SH_FIRST  = 29,
   parameter int LEN_NORM  = 26,
   parameter int SH_NORM   = 3,
   parameter int LEN_TRIG  = 27,
   parameter int SH_TRIG   = 4,
   parameter int LEN_DIFF  = 28,
   parameter int SH_DIFF   = 5,
   parameter bit DIFF_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adc_en,
   input  logic             half_tick,
   input  logic             sw_start,
   input  logic             auto_en,
   input  logic             free_run,
   input  logic             trig_in,
   input  logic             diff_mode,
   input  logic             flag_clr,
   input  logic [MUX_W-1:0] mux_in,
   input  logic [RES_W-1:0] sample_in,
   output logic             busy,
   output logic             sh_strobe,
   output logic             presc_clr,
   output logic             mux_upd,
   output logic [MUX_W-1:0] mux_q,
   output logic             irq_flag,
   output logic             res_valid,
   output logic [OUT_W-1:0] result
);
   if (RES_W > OUT_W || RES_W < 1) begin : g_bad_res
      $error("RES_W must lie in 1..OUT_W");
   end
   if (OUT_W != 16) begin : g_bad_out
      $error("result port is 16 bits wide");
   end

   logic pend;
   logic pend_trig;
   logic trig_acc;
   logic running;
   logic take;
   logic hr;
   logic done_ev;

   assign take = pend & half_tick & adc_en;
   assign busy = pend | running;

   adc_start_ctl start_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (adc_en),
      .sw_start  (sw_start),
      .auto_en   (auto_en),
      .trig_in   (trig_in),
      .running   (running),
      .take      (take),
      .pend      (pend),
      .pend_trig (pend_trig),
      .trig_acc  (trig_acc),
      .presc_clr (presc_clr)
   );

   adc_phase_gen #(.PH_W(2)) phase_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (adc_en),
      .tick    (half_tick),
      .realign (trig_acc),
      .hr      (hr)
   );

   adc_timebase #(
      .LEN_FIRST (LEN_FIRST), .SH_FIRST (SH_FIRST),
      .LEN_NORM  (LEN_NORM),  .SH_NORM  (SH_NORM),
      .LEN_TRIG  (LEN_TRIG),  .SH_TRIG  (SH_TRIG),
      .LEN_DIFF  (LEN_DIFF),  .SH_DIFF  (SH_DIFF),
      .DIFF_EN   (DIFF_EN)
   ) time_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (adc_en),
      .tick      (half_tick),
      .take      (take),
      .pend_trig (pend_trig),
      .free_run  (free_run),
      .auto_en   (auto_en),
      .diff_mode (diff_mode),
      .hr        (hr),
      .running   (running),
      .sh_ev     (sh_strobe),
      .done_ev   (done_ev)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result    <= '0;
         res_valid <= 1'b0;
         mux_upd   <= 1'b0;
         mux_q     <= '0;
         irq_flag  <= 1'b0;
      end else begin
         res_valid <= done_ev;
         mux_upd   <= done_ev;
         if (done_ev)       result <= OUT_W'(sample_in);
         if (take || done_ev) mux_q <= mux_in;
         if (done_ev)       irq_flag <= 1'b1;
         else if (flag_clr) irq_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic adc_en,
   input logic flag_clr,
   input logic busy,
   input logic sh_strobe,
   input logic presc_clr,
   input logic mux_upd,
   input logic irq_flag,
   input logic res_valid
);
   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);
   p_valid_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (irq_flag && mux_upd));
   p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag);
   p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_en |=> !busy);
   p_presc_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
      presc_clr |=> (!presc_clr && busy));
   p_sh_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sh_strobe |-> busy);
endmodule

bind adc_conv_seq adc_conv_seq_chk chk_i (.*);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adc_en = 0, half_tick = 0, sw_start = 0, auto_en = 0, free_run = 0;
   logic trig_in = 0, diff_mode = 0, flag_clr = 0;
   logic [4:0] mux_in = 0;
   logic [9:0] sample_in = 0;
   logic busy, sh_strobe, presc_clr, mux_upd, irq_flag, res_valid;
   logic [4:0] mux_q;
   logic [15:0] result;

   int total = 0, bad = 0;
   int gcnt = 0, g0 = 0, div = 0;

   always #4 clk = ~clk;

   adc_conv_seq dut_i (.*);

   // reference model state
   int m_pend, m_ptrig, m_run, m_cnt, m_len, m_shp, m_first, m_ph, m_trigd, m_lastlen;
   logic e_sh, e_val, e_upd, e_pc, e_irq;
   logic [15:0] e_res;
   logic [4:0] e_mux;

   always @(posedge clk) begin
      if (half_tick) gcnt <= gcnt + 1;
   end

   always @(posedge clk) begin : model
      bit hrb, trise, done, reacc;
      if (!rst_n) begin
         m_pend = 0; m_ptrig = 0; m_run = 0; m_cnt = 0; m_len = 0; m_shp = 0;
         m_first = 1; m_ph = 0; m_trigd = 0; m_lastlen = 0;
         e_sh = 0; e_val = 0; e_upd = 0; e_pc = 0; e_irq = 0; e_res = 0; e_mux = 0;
      end else begin
         hrb = (m_ph >= 2); trise = trig_in && (m_trigd == 0);
         done = 0; reacc = 0;
         e_sh = 0; e_val = 0; e_upd = 0; e_pc = 0;
         if (!adc_en) begin
            m_pend = 0; m_run = 0; m_first = 1;
         end else if (m_pend != 0 && half_tick) begin
            m_pend = 0; m_run = 1; m_cnt = 0; e_mux = mux_in;
            if (m_first != 0)              begin m_len = 50; m_shp = 29; end
            else if (m_ptrig != 0)         begin m_len = 27; m_shp = 4;  end
            else if (diff_mode && hrb)     begin m_len = 28; m_shp = 5;  end
            else                           begin m_len = 26; m_shp = 3;  end
            m_first = 0; m_lastlen = m_len;
         end else if (m_run != 0 && half_tick) begin
            m_cnt = m_cnt + 1;
            if (m_cnt == m_shp) e_sh = 1;
            if (m_cnt == m_len) begin
               done = 1; e_val = 1; e_upd = 1; e_res = {6'd0, sample_in}; e_mux = mux_in;
               if (free_run && !auto_en) begin
                  m_cnt = 0;
                  if (diff_mode && hrb) begin m_len = 28; m_shp = 5; end
                  else begin m_len = 26; m_shp = 3; end
               end else m_run = 0;
            end
         end else if (m_pend == 0 && m_run == 0) begin
            if (auto_en && trise) begin m_pend = 1; m_ptrig = 1; e_pc = 1; reacc = 1; end
            else if (!auto_en && sw_start) begin m_pend = 1; m_ptrig = 0; end
         end
         if (!adc_en || reacc) m_ph = 0;
         else if (half_tick) m_ph = (m_ph + 1) % 4;
         if (flag_clr) e_irq = 0;
         if (done) e_irq = 1;
         m_trigd = trig_in ? 1 : 0;
      end
   end

   // per-cycle comparison against the model (R6 and all outputs)
   always @(negedge clk) begin
      if (rst_n) begin
         total++;
         if (busy !== ((m_pend != 0) || (m_run != 0)) || sh_strobe !== e_sh ||
             res_valid !== e_val || mux_upd !== e_upd || presc_clr !== e_pc ||
             irq_flag !== e_irq || result !== e_res || mux_q !== e_mux) begin
            bad++;
            $display("FAIL R6 model cycle: act b%0b s%0b v%0b u%0b p%0b i%0b r%h m%h exp b%0b s%0b v%0b u%0b p%0b i%0b r%h m%h",
               busy, sh_strobe, res_valid, mux_upd, presc_clr, irq_flag, result, mux_q,
               (m_pend != 0) || (m_run != 0), e_sh, e_val, e_upd, e_pc, e_irq, e_res, e_mux);
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw_start = 1;
      @(negedge clk); sw_start = 0; g0 = gcnt;
   endtask

   task automatic measure(output int sh, output int ln);
      sh = -1;
      do begin
         @(negedge clk);
         if (sh_strobe && sh < 0) sh = gcnt - g0 - 1;
      end while (!res_valid);
      ln = gcnt - g0 - 1;
   endtask

   task automatic idle_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      forever begin
         @(negedge clk);
         div = (div + 1) % 3;
         half_tick = (div == 0);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int sh, ln, g1;
      bit seen26, seen28;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(busy == 0 && irq_flag == 0 && res_valid == 0 && presc_clr == 0 &&
          result == 0 && mux_q == 0, "R1 reset state", int'(busy), 0);

      adc_en = 1; mux_in = 5'd9; sample_in = 10'h2A5;
      pulse_sw();
      measure(sh, ln);
      chk(sh == 29, "R2 first S&H", sh, 29);
      chk(ln == 50, "R2 first length", ln, 50);
      chk(result == 16'h02A5, "R6 result zero-extended", int'(result), 16'h02A5);
      chk(mux_q == 5'd9 && irq_flag, "R6 mux and flag", int'(mux_q), 9);

      idle_wait(10);
      chk(irq_flag == 1, "R9 flag held", int'(irq_flag), 1);
      @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
      chk(irq_flag == 0, "R9 flag cleared", int'(irq_flag), 0);

      sample_in = 10'h13C; mux_in = 5'd3;
      pulse_sw();
      idle_wait(6);
      @(negedge clk); sw_start = 1; @(negedge clk); sw_start = 0;
      measure(sh, ln);
      chk(sh == 3, "R3 normal S&H", sh, 3);
      chk(ln == 26, "R3 normal length", ln, 26);
      chk(result == 16'h013C, "R6 second result", int'(result), 16'h013C);
      idle_wait(2);
      chk(busy == 0, "R8 busy request ignored", int'(busy), 0);

      diff_mode = 1; seen26 = 0; seen28 = 0;
      for (int a = 0; a < 10; a++) begin
         idle_wait(a % 5);
         pulse_sw();
         measure(sh, ln);
         chk(ln == m_lastlen && (ln == 26 || ln == 28), "R5 differential length", ln, m_lastlen);
         chk(sh == (ln == 28 ? 5 : 3), "R5 differential S&H", sh, ln == 28 ? 5 : 3);
         if (ln == 26) seen26 = 1;
         if (ln == 28) seen28 = 1;
      end
      chk(seen26 && seen28, "R5 both phases reached", int'(seen28), 1);
      diff_mode = 0;

      auto_en = 1;
      pulse_sw();
      idle_wait(5);
      chk(busy == 0, "R11 software start ignored in trigger mode", int'(busy), 0);
      @(negedge clk); trig_in = 1;
      @(negedge clk); g0 = gcnt;
      chk(presc_clr == 1, "R4 prescaler realign pulse", int'(presc_clr), 1);
      measure(sh, ln);
      trig_in = 0;
      chk(sh == 4, "R4 trigger S&H", sh, 4);
      chk(ln == 27, "R4 trigger length", ln, 27);
      auto_en = 0;

      idle_wait(3);
      @(negedge clk); trig_in = 1; idle_wait(4); trig_in = 0;
      chk(busy == 0 && presc_clr == 0, "R11 trigger ignored without auto mode", int'(busy), 0);

      free_run = 1;
      pulse_sw();
      measure(sh, ln);
      chk(ln == 26, "R7 free-run first length", ln, 26);
      g1 = gcnt;
      do @(negedge clk); while (!res_valid);
      chk(gcnt - g1 == 26, "R7 free-run restart spacing", gcnt - g1, 26);
      free_run = 0;
      do @(negedge clk); while (busy);

      pulse_sw();
      idle_wait(20);
      adc_en = 0;
      @(negedge clk);
      chk(busy == 0, "R10 disable aborts", int'(busy), 0);
      adc_en = 1;
      pulse_sw();
      measure(sh, ln);
      chk(ln == 50 && sh == 29, "R10 first conversion re-armed", ln, 50);

      idle_wait(4);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule